// File: doc/BRIEF.md
# Two-Wire Bus Master Control Register Block

This block sits between a processor-side register port and a byte-level engine for a two-wire serial bus. Software programs nine 8-bit registers at word-aligned byte offsets. It drives a transfer by writing the control and data registers, and it follows progress through a 5-bit phase code. The status register returns that code shifted left by three. The block converts register accesses into byte-level operations toward a bus engine: address-with-start, send byte, receive byte and stop. It moves the phase code on every result and raises an interrupt flag and line for each completed step.

Each register access is accepted while `reg_ready` is high. An access that starts a bus operation drops `reg_ready` until the engine answers with `bus_done`. Reads return on `reg_rdata` with a one-cycle `reg_rvalid` pulse. For a read that has to fetch a byte from the bus, that pulse comes only once the byte has arrived. The `CLR_ON_ONE` parameter selects the rule for clearing the interrupt flag.

Top module: `i2c_ctl_top`

## Requirements
- R1: After reset the status register (offset 0x10) reads 0xF8 (idle code 0x1F shifted left by 3). The line control register (0x20) reads 0x3A. All other registers, and any offset that is not one of 0x00, 0x04, ..., 0x20, read 0x00.
- R2: Writes are stored through per-register masks and read back: address 0x00 and extended address 0x04 keep all 8 bits, clock control 0x14 keeps 0x7F, feature 0x1C keeps 0x03, line control 0x20 keeps 0x3F. Writes to status are ignored.
- R3: Control register 0x0C uses these bits: [7] interrupt enable, [6] bus enable, [5] start, [4] stop, [3] interrupt flag, [2] assert-ack. The writable mask is 0xFC. A control write with bit 5 set moves the status to 0x08 (code 1) when it was idle, and to 0x10 (code 2) otherwise. Bit 5 always reads back 0.
- R4: In status 0x08 or 0x10, a data write (0x08) issues a bus operation with code 0 (address). It carries `bus_addr` = data[7:1] and `bus_rw` = data[0], where 1 means read. If the target acks, the status becomes 0x40 (code 8) when reading and 0x18 (code 3) when writing. If it nacks, the status becomes 0x20 (code 4) in both cases.
- R5: In status 0x18 or 0x28, a data write issues a bus operation with code 1 (send) carrying the byte. An ack gives status 0x28 (code 5). A nack gives 0x30 (code 6), followed automatically by an operation with code 3 (stop). In any other phase, a data write only stores the byte.
- R6: A data write has no effect while soft reset (0x18 bit 0) is set or bus enable is clear. No bus operation is issued and the data register keeps its value.
- R7: In status 0x40, 0x50 or 0x58, a data read issues a bus operation with code 2 (receive) and returns the received byte. The status then becomes 0x50 (code 10) if assert-ack is set, and 0x58 (code 11) otherwise. A status read in 0x40 returns 0x40 and makes the same transition without any bus operation.
- R8: A control write switches status 0x50 to 0x58 when it clears assert-ack, and switches 0x58 to 0x50 when it sets assert-ack.
- R9: A control write with bit 4 set returns the status to idle 0xF8. If a transfer was open (status not idle), it issues a bus operation with code 3 (stop). Bit 4 always reads back 0.
- R10: After each successful step and after each control write, the interrupt flag (control bit 3) is set only when soft reset is clear, bus enable is set and the status is not idle. `irq` is raised at that moment only if interrupt enable is set.
- R11: With `CLR_ON_ONE`=0, a control write with bit 3 at 0 lowers `irq` and bit 3 is stored as written. With `CLR_ON_ONE`=1, a control write with bit 3 at 1 clears the flag and lowers `irq`. In both modes the R10 rule is then applied again.
- R12: Control writes are ignored while soft reset is set. Writing soft reset from 1 to 0 returns every register to its reset value.
- R13: While a bus operation is pending, `bus_req` stays high with stable `bus_op` and byte fields and `reg_ready` stays low. The operation completes in the cycle where `bus_req` and `bus_done` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 8 | Write data |
| reg_ready | output | 1 | Block can accept an access |
| reg_rdata | output | 8 | Read data |
| reg_rvalid | output | 1 | Read data valid pulse |
| bus_req | output | 1 | Bus operation request, held until done |
| bus_op | output | 2 | Operation: 0 address, 1 send, 2 receive, 3 stop |
| bus_addr | output | 7 | Target address for operation 0 |
| bus_rw | output | 1 | Direction for operation 0, 1 = read |
| bus_wbyte | output | 8 | Byte to send for operation 1 |
| bus_done | input | 1 | Engine finished the operation |
| bus_ack | input | 1 | Engine result: 1 = ack |
| bus_rbyte | input | 8 | Byte received for operation 2 |
| irq | output | 1 | Interrupt line |

## Verification
A register write takes effect at the clock edge that accepts it. A read that needs no bus operation presents its data with `reg_rvalid` in the cycle right after acceptance. A bus operation raises `bus_req` one cycle after acceptance. Status, data and the interrupt change at the edge that sees `bus_done`, and `reg_ready` returns in the following cycle. A nacked send adds one idle cycle and a stop operation before `reg_ready` returns. The bench drives on falling edges, waits for `reg_ready` or `reg_rvalid` before it samples any register, and counts bus operations in its own engine model. This lets it confirm which steps touched the bus and which did not.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;

    localparam int REG_W   = 8;
    localparam int PHASE_W = 5;
    localparam int OFS_W   = 6;

    typedef enum logic [PHASE_W-1:0] {
        PH_BUS_ERR  = 5'd0,
        PH_START    = 5'd1,
        PH_RSTART   = 5'd2,
        PH_WA_ACK   = 5'd3,
        PH_WA_NACK  = 5'd4,
        PH_TX_ACK   = 5'd5,
        PH_TX_NACK  = 5'd6,
        PH_ARB_LOST = 5'd7,
        PH_RA_ACK   = 5'd8,
        PH_RA_NACK  = 5'd9,
        PH_RX_ACK   = 5'd10,
        PH_RX_NACK  = 5'd11,
        PH_IDLE     = 5'h1F
    } phase_t;

    typedef enum logic [1:0] {
        OP_ADDR = 2'd0,
        OP_SEND = 2'd1,
        OP_RECV = 2'd2,
        OP_STOP = 2'd3
    } bus_op_t;

    typedef enum logic [2:0] {
        PEND_NONE,
        PEND_ADDR,
        PEND_SEND,
        PEND_RECV,
        PEND_STOP,
        PEND_STOP_NEXT
    } pend_t;

    localparam logic [OFS_W-1:0] OFS_TADDR = 6'h00;
    localparam logic [OFS_W-1:0] OFS_XADDR = 6'h04;
    localparam logic [OFS_W-1:0] OFS_DATA  = 6'h08;
    localparam logic [OFS_W-1:0] OFS_CTRL  = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_STAT  = 6'h10;
    localparam logic [OFS_W-1:0] OFS_CLK   = 6'h14;
    localparam logic [OFS_W-1:0] OFS_SRST  = 6'h18;
    localparam logic [OFS_W-1:0] OFS_FEAT  = 6'h1C;
    localparam logic [OFS_W-1:0] OFS_LINE  = 6'h20;

    localparam logic [REG_W-1:0] CTRL_MASK = 8'hFC;
    localparam logic [REG_W-1:0] CLK_MASK  = 8'h7F;
    localparam logic [REG_W-1:0] FEAT_MASK = 8'h03;
    localparam logic [REG_W-1:0] LINE_MASK = 8'h3F;
    localparam logic [REG_W-1:0] LINE_RST  = 8'h3A;

    localparam int B_IEN  = 7;
    localparam int B_BEN  = 6;
    localparam int B_STA  = 5;
    localparam int B_STP  = 4;
    localparam int B_FLAG = 3;
    localparam int B_AACK = 2;

    typedef struct packed {
        logic [REG_W-1:0] taddr;
        logic [REG_W-1:0] xaddr;
        logic [REG_W-1:0] data;
        logic [REG_W-1:0] cntr;
        logic [REG_W-1:0] clkc;
        logic [REG_W-1:0] feat;
        logic [REG_W-1:0] line;
        logic             srst;
        phase_t           stat;
        logic             irq;
        pend_t            pend;
        logic [REG_W-1:0] rdata;
        logic             rvalid;
    } ctl_st_t;

endpackage

// File: rtl/i2c_ctl_rdmux.sv
module i2c_ctl_rdmux
    import i2c_ctl_pkg::*;
(
    input  ctl_st_t           st,
    input  logic [OFS_W-1:0]  ofs,
    output logic [REG_W-1:0]  value
);

    logic [REG_W-1:0] stat_byte;
    assign stat_byte = {st.stat, 3'b000};

    always_comb begin
        unique case (ofs)
            OFS_TADDR: value = st.taddr;
            OFS_XADDR: value = st.xaddr;
            OFS_DATA:  value = st.data;
            OFS_CTRL:  value = st.cntr;
            OFS_STAT:  value = stat_byte;
            OFS_CLK:   value = st.clkc;
            OFS_SRST:  value = {{(REG_W-1){1'b0}}, st.srst};
            OFS_FEAT:  value = st.feat;
            OFS_LINE:  value = st.line;
            default:   value = '0;
        endcase
    end

endmodule

// File: rtl/i2c_ctl_busreq.sv
module i2c_ctl_busreq
    import i2c_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  bus_op_t          launch_op,
    input  logic [REG_W-1:0] launch_byte,
    input  logic             done,
    output logic             req,
    output bus_op_t          op,
    output logic [REG_W-1:0] byte_o
);

    typedef struct packed {
        logic             req;
        bus_op_t          op;
        logic [REG_W-1:0] bval;
    } breq_t;

    breq_t q, d;

    always_comb begin
        d = q;
        if (launch) begin
            d.req  = 1'b1;
            d.op   = launch_op;
            d.bval = launch_byte;
        end else if (q.req && done) begin
            d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{req: 1'b0, op: OP_STOP, bval: '0};
        end else begin
            q <= d;
        end
    end

    assign req    = q.req;
    assign op     = q.op;
    assign byte_o = q.bval;

endmodule

// File: rtl/i2c_ctl_top.sv
module i2c_ctl_top
    import i2c_ctl_pkg::*;
#(
    parameter bit CLR_ON_ONE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              reg_ready,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              reg_rvalid,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [REG_W-2:0]  bus_addr,
    output logic              bus_rw,
    output logic [REG_W-1:0]  bus_wbyte,
    input  logic              bus_done,
    input  logic              bus_ack,
    input  logic [REG_W-1:0]  bus_rbyte,
    output logic              irq
);

    ctl_st_t q, d;

    logic             launch;
    bus_op_t          launch_op;
    logic [REG_W-1:0] launch_byte;
    bus_op_t          op_w;
    logic [REG_W-1:0] byte_w;
    logic [REG_W-1:0] mux_val;
    logic             bus_fin;
    logic             acc_wr;
    logic             acc_rd;

    // views for the bound checker
    logic [REG_W-1:0] cntr_w;
    phase_t           stat_w;
    logic             srst_w;

    function automatic ctl_st_t reset_state();
        ctl_st_t s;
        s.taddr  = '0;
        s.xaddr  = '0;
        s.data   = '0;
        s.cntr   = '0;
        s.clkc   = '0;
        s.feat   = '0;
        s.line   = LINE_RST;
        s.srst   = 1'b0;
        s.stat   = PH_IDLE;
        s.irq    = 1'b0;
        s.pend   = PEND_NONE;
        s.rdata  = '0;
        s.rvalid = 1'b0;
        return s;
    endfunction

    // set the flag (and line when enabled) if the block is active
    function automatic ctl_st_t raise_flag(ctl_st_t s);
        ctl_st_t r;
        r = s;
        if (!r.srst && r.cntr[B_BEN] && (r.stat != PH_IDLE)) begin
            r.cntr[B_FLAG] = 1'b1;
            if (r.cntr[B_IEN]) begin
                r.irq = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic phase_t rx_phase(logic aack);
        return aack ? PH_RX_ACK : PH_RX_NACK;
    endfunction

    i2c_ctl_rdmux u_rdmux (
        .st    (q),
        .ofs   (reg_addr),
        .value (mux_val)
    );

    assign reg_ready = (q.pend == PEND_NONE);
    assign bus_fin   = bus_req && bus_done;
    assign acc_wr    = reg_ready && reg_wr;
    assign acc_rd    = reg_ready && reg_rd && !reg_wr;

    always_comb begin
        d           = q;
        d.rvalid    = 1'b0;
        launch      = 1'b0;
        launch_op   = OP_STOP;
        launch_byte = q.data;

        if (q.pend == PEND_STOP_NEXT) begin
            launch    = 1'b1;
            launch_op = OP_STOP;
            d.pend    = PEND_STOP;
        end else if (bus_fin) begin
            d.pend = PEND_NONE;
            unique case (q.pend)
                PEND_ADDR: begin
                    if (bus_ack) begin
                        d.stat = q.data[0] ? PH_RA_ACK : PH_WA_ACK;
                        d      = raise_flag(d);
                    end else begin
                        d.stat = PH_WA_NACK;
                    end
                end
                PEND_SEND: begin
                    if (bus_ack) begin
                        d.stat = PH_TX_ACK;
                        d      = raise_flag(d);
                    end else begin
                        d.stat = PH_TX_NACK;
                        d.pend = PEND_STOP_NEXT;
                    end
                end
                PEND_RECV: begin
                    d.data   = bus_rbyte;
                    d.rdata  = bus_rbyte;
                    d.rvalid = 1'b1;
                    d.stat   = rx_phase(q.cntr[B_AACK]);
                    d        = raise_flag(d);
                end
                default: ;
            endcase
        end else if (acc_wr) begin
            unique case (reg_addr)
                OFS_TADDR: d.taddr = reg_wdata;
                OFS_XADDR: d.xaddr = reg_wdata;
                OFS_CLK:   d.clkc  = reg_wdata & CLK_MASK;
                OFS_FEAT:  d.feat  = reg_wdata & FEAT_MASK;
                OFS_LINE:  d.line  = reg_wdata & LINE_MASK;
                OFS_SRST: begin
                    if (!reg_wdata[0] && q.srst) begin
                        d = reset_state();
                    end else begin
                        d.srst = reg_wdata[0];
                    end
                end
                OFS_DATA: begin
                    if (!q.srst && q.cntr[B_BEN]) begin
                        d.data = reg_wdata;
                        unique case (q.stat)
                            PH_START, PH_RSTART: begin
                                launch      = 1'b1;
                                launch_op   = OP_ADDR;
                                launch_byte = reg_wdata;
                                d.pend      = PEND_ADDR;
                            end
                            PH_WA_ACK, PH_TX_ACK: begin
                                launch      = 1'b1;
                                launch_op   = OP_SEND;
                                launch_byte = reg_wdata;
                                d.pend      = PEND_SEND;
                            end
                            default: ;
                        endcase
                    end
                end
                OFS_CTRL: begin
                    if (!q.srst) begin
                        d.cntr = reg_wdata & CTRL_MASK;
                        if (d.cntr[B_STA]) begin
                            d.stat = (q.stat == PH_IDLE) ? PH_START : PH_RSTART;
                            d.cntr[B_STA] = 1'b0;
                        end
                        if (d.cntr[B_STP]) begin
                            if (q.stat != PH_IDLE) begin
                                launch    = 1'b1;
                                launch_op = OP_STOP;
                                d.pend    = PEND_STOP;
                            end
                            d.stat = PH_IDLE;
                            d.cntr[B_STP] = 1'b0;
                        end
                        if (!CLR_ON_ONE && !d.cntr[B_FLAG]) begin
                            d.irq = 1'b0;
                        end else if (CLR_ON_ONE && d.cntr[B_FLAG]) begin
                            d.cntr[B_FLAG] = 1'b0;
                            d.irq = 1'b0;
                        end
                        if (!d.cntr[B_AACK] && (d.stat == PH_RX_ACK)) begin
                            d.stat = PH_RX_NACK;
                        end else if (d.cntr[B_AACK] && (d.stat == PH_RX_NACK)) begin
                            d.stat = PH_RX_ACK;
                        end
                        d = raise_flag(d);
                    end
                end
                default: ;
            endcase
        end else if (acc_rd) begin
            d.rdata  = mux_val;
            d.rvalid = 1'b1;
            if (reg_addr == OFS_DATA &&
                (q.stat == PH_RA_ACK || q.stat == PH_RX_ACK || q.stat == PH_RX_NACK)) begin
                launch    = 1'b1;
                launch_op = OP_RECV;
                d.pend    = PEND_RECV;
                d.rvalid  = 1'b0;
            end else if (reg_addr == OFS_STAT && q.stat == PH_RA_ACK) begin
                d.stat = rx_phase(q.cntr[B_AACK]);
                d      = raise_flag(d);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= reset_state();
        end else begin
            q <= d;
        end
    end

    i2c_ctl_busreq u_busreq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_op   (launch_op),
        .launch_byte (launch_byte),
        .done        (bus_done),
        .req         (bus_req),
        .op          (op_w),
        .byte_o      (byte_w)
    );

    assign bus_op     = op_w;
    assign bus_addr   = byte_w[REG_W-1:1];
    assign bus_rw     = byte_w[0];
    assign bus_wbyte  = byte_w;
    assign reg_rdata  = q.rdata;
    assign reg_rvalid = q.rvalid;
    assign irq        = q.irq;
    assign cntr_w     = q.cntr;
    assign stat_w     = q.stat;
    assign srst_w     = q.srst;

endmodule

// File: rtl/i2c_ctl_chk.sv
module i2c_ctl_chk
    import i2c_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [OFS_W-1:0] reg_addr,
    input logic             reg_ready,
    input logic             reg_rvalid,
    input logic             bus_req,
    input logic [1:0]       bus_op,
    input logic [REG_W-1:0] bus_wbyte,
    input logic             bus_done,
    input logic             irq,
    input logic [REG_W-1:0] cntr_w,
    input phase_t           stat_w,
    input logic             srst_w
);

    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_op) && $stable(bus_wbyte)));

    p_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !reg_ready);

    p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (cntr_w[B_IEN] && cntr_w[B_BEN] && stat_w != PH_IDLE && !srst_w));

    p_srst_ctrl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_w && reg_wr && reg_ready && reg_addr == OFS_CTRL) |=> $stable(cntr_w));

    p_selfclear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_ready && reg_addr == OFS_CTRL) |=> !cntr_w[B_STA]);

    p_selfclear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_ready && reg_addr == OFS_CTRL) |=> !cntr_w[B_STP]);

    p_rvalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> ($past(reg_rd && reg_ready) || $past(bus_req && bus_done)));

endmodule

bind i2c_ctl_top i2c_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_ready  (reg_ready),
    .reg_rvalid (reg_rvalid),
    .bus_req    (bus_req),
    .bus_op     (bus_op),
    .bus_wbyte  (bus_wbyte),
    .bus_done   (bus_done),
    .irq        (irq),
    .cntr_w     (cntr_w),
    .stat_w     (stat_w),
    .srst_w     (srst_w)
);

// File: tb/i2c_ctl_top_tb_top.sv
module i2c_ctl_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_ready;
    logic [7:0] reg_rdata;
    logic       reg_rvalid;
    logic       bus_req;
    logic [1:0] bus_op;
    logic [6:0] bus_addr;
    logic       bus_rw;
    logic [7:0] bus_wbyte;
    logic       bus_done = 1'b0;
    logic       bus_ack = 1'b1;
    logic [7:0] bus_rbyte = '0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // engine model state
    logic       resp_ack = 1'b1;
    logic [7:0] resp_byte = 8'h00;
    int         op_cnt = 0;
    int         wait_cnt = 0;
    logic [1:0] last_op = 2'd0;
    logic [6:0] last_addr = '0;
    logic       last_rw = 1'b0;
    logic [7:0] last_byte = '0;

    always #2 clk = ~clk;

    i2c_ctl_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_ready  (reg_ready),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .bus_req    (bus_req),
        .bus_op     (bus_op),
        .bus_addr   (bus_addr),
        .bus_rw     (bus_rw),
        .bus_wbyte  (bus_wbyte),
        .bus_done   (bus_done),
        .bus_ack    (bus_ack),
        .bus_rbyte  (bus_rbyte),
        .irq        (irq)
    );

    // byte-level engine: answers two cycles after a request
    always @(negedge clk) begin
        if (bus_done) begin
            bus_done <= 1'b0;
            wait_cnt <= 0;
        end else if (bus_req) begin
            if (wait_cnt == 1) begin
                bus_done  <= 1'b1;
                bus_ack   <= resp_ack;
                bus_rbyte <= resp_byte;
                op_cnt    <= op_cnt + 1;
                last_op   <= bus_op;
                last_addr <= bus_addr;
                last_rw   <= bus_rw;
                last_byte <= bus_wbyte;
            end
            wait_cnt <= wait_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 50000)", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_ready();
        while (!reg_ready) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] v);
        wait_ready();
        reg_addr  = a;
        reg_wdata = v;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        wait_ready();
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] v);
        wait_ready();
        reg_addr = a;
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        while (!reg_rvalid) @(negedge clk);
        v = reg_rdata;
        wait_ready();
    endtask

    task automatic rchk(input string tag, input logic [5:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, int'(v), int'(exp));
    endtask

    // {write, offset, wdata, expected read}
    localparam int NVEC = 16;
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 8'h10, 8'h00, 8'hF8},
        {1'b0, 8'h0C, 8'h00, 8'h00},
        {1'b0, 8'h20, 8'h00, 8'h3A},
        {1'b0, 8'h14, 8'h00, 8'h00},
        {1'b0, 8'h24, 8'h00, 8'h00},
        {1'b0, 8'h02, 8'h00, 8'h00},
        {1'b1, 8'h14, 8'hFF, 8'h00},
        {1'b0, 8'h14, 8'h00, 8'h7F},
        {1'b1, 8'h1C, 8'hFF, 8'h00},
        {1'b0, 8'h1C, 8'h00, 8'h03},
        {1'b1, 8'h20, 8'hFF, 8'h00},
        {1'b0, 8'h20, 8'h00, 8'h3F},
        {1'b1, 8'h00, 8'hA5, 8'h00},
        {1'b0, 8'h00, 8'h00, 8'hA5},
        {1'b1, 8'h10, 8'h00, 8'h00},
        {1'b0, 8'h10, 8'h00, 8'hF8}
    };

    initial begin
        int base;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk("R1 irq after reset", int'(irq), 0);
        chk("R13 ready after reset", int'(reg_ready), 1);

        // R1 / R2 register table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][24]) begin
                wr(VEC[i][21:16], VEC[i][15:8]);
            end else begin
                rd(VEC[i][21:16], v);
                chk((i < 6) ? "R1 reset value" : "R2 masked readback", int'(v), int'(VEC[i][7:0]));
            end
        end
        wr(6'h04, 8'h5A);
        rchk("R2 extended address", 6'h04, 8'h5A);

        // R6: bus disabled -> data write ignored
        wr(6'h08, 8'h77);
        rchk("R6 data kept while disabled", 6'h08, 8'h00);
        chk("R6 no bus op while disabled", op_cnt, 0);

        // R10: enabled but idle -> no flag
        wr(6'h0C, 8'h40);
        rchk("R10 no flag when idle", 6'h0C, 8'h40);

        // R3 start from idle
        wr(6'h0C, 8'hE0);
        rchk("R3 start from idle", 6'h10, 8'h08);
        rchk("R3 start self-clear and R10 flag", 6'h0C, 8'hC8);
        chk("R10 irq raised", int'(irq), 1);

        // R4 write address ack
        resp_ack = 1'b1;
        wr(6'h08, 8'hA0);
        chk("R4 op code", int'(last_op), 0);
        chk("R4 address", int'(last_addr), 8'h50);
        chk("R4 direction", int'(last_rw), 0);
        rchk("R4 write address acked", 6'h10, 8'h18);

        // R5 send with ack, R13 handshake observation
        wait_ready();
        reg_addr = 6'h08; reg_wdata = 8'h3C; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R13 request pending", int'(bus_req), 1);
        chk("R13 not ready while pending", int'(reg_ready), 0);
        wait_ready();
        chk("R5 send op", int'(last_op), 1);
        chk("R5 send byte", int'(last_byte), 8'h3C);
        rchk("R5 send acked", 6'h10, 8'h28);

        // R5 send with nack -> stop follows
        base = op_cnt;
        resp_ack = 1'b0;
        wr(6'h08, 8'h11);
        chk("R5 nack adds stop", op_cnt - base, 2);
        chk("R5 last op stop", int'(last_op), 3);
        rchk("R5 send nacked", 6'h10, 8'h30);
        base = op_cnt;
        wr(6'h08, 8'h22);
        chk("R5 no op outside send phases", op_cnt - base, 0);
        rchk("R5 data stored only", 6'h08, 8'h22);

        // R9 stop with flag written 1 (R11 mode 0: line stays)
        base = op_cnt;
        wr(6'h0C, 8'hD8);
        rchk("R9 stop to idle", 6'h10, 8'hF8);
        chk("R9 stop op issued", op_cnt - base, 1);
        chk("R11 irq kept when flag written 1", int'(irq), 1);
        rchk("R11 flag stored as written", 6'h0C, 8'hC8);
        wr(6'h0C, 8'hC0);
        chk("R11 irq lowered by writing 0", int'(irq), 0);
        base = op_cnt;
        wr(6'h0C, 8'hD0);
        chk("R9 no stop op when idle", op_cnt - base, 0);

        // R3 repeated start, R4 read address
        wr(6'h0C, 8'hE0);
        wr(6'h0C, 8'hE0);
        rchk("R3 repeated start", 6'h10, 8'h10);
        resp_ack = 1'b1;
        wr(6'h08, 8'hA1);
        chk("R4 read direction", int'(last_rw), 1);
        base = op_cnt;
        rchk("R7 status read returns old code", 6'h10, 8'h40);
        rchk("R7 status read advances", 6'h10, 8'h58);
        chk("R7 status read no bus op", op_cnt - base, 0);

        // R8 ack toggle
        wr(6'h0C, 8'hC4);
        rchk("R8 nack to ack", 6'h10, 8'h50);

        // R7 receive
        resp_byte = 8'h9E;
        base = op_cnt;
        rchk("R7 received byte", 6'h08, 8'h9E);
        chk("R7 receive op", int'(last_op), 2);
        chk("R7 one receive op", op_cnt - base, 1);
        rchk("R7 status with ack", 6'h10, 8'h50);
        wr(6'h0C, 8'hC0);
        rchk("R8 ack to nack", 6'h10, 8'h58);
        resp_byte = 8'h31;
        rchk("R7 received byte nack", 6'h08, 8'h31);
        rchk("R7 status with nack", 6'h10, 8'h58);

        // R4 address nack on read
        wr(6'h0C, 8'hD0);
        wr(6'h0C, 8'hE0);
        resp_ack = 1'b0;
        wr(6'h08, 8'hA1);
        rchk("R4 address nack", 6'h10, 8'h20);
        wr(6'h0C, 8'hD0);

        // R12 soft reset
        wr(6'h14, 8'h12);
        wr(6'h18, 8'h01);
        wr(6'h0C, 8'h40);
        rchk("R12 control ignored in soft reset", 6'h0C, 8'hC0);
        wr(6'h18, 8'h00);
        rchk("R12 status default", 6'h10, 8'hF8);
        rchk("R12 control default", 6'h0C, 8'h00);
        rchk("R12 clock default", 6'h14, 8'h00);
        rchk("R12 line default", 6'h20, 8'h3A);
        rchk("R12 address default", 6'h00, 8'h00);

        // R10 bus disabled: start moves phase but no flag
        wr(6'h0C, 8'hA0);
        rchk("R10 phase moves with bus off", 6'h10, 8'h08);
        rchk("R10 no flag with bus off", 6'h0C, 8'h80);
        chk("R10 no irq with bus off", int'(irq), 0);
        base = op_cnt;
        wr(6'h08, 8'hA0);
        chk("R6 no address op with bus off", op_cnt - base, 0);
        rchk("R6 data unchanged", 6'h08, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule